// File: doc/BRIEF.md
# Receive Character Compare Engine

This block sits on the byte stream leaving a serial receiver. Every byte that arrives with its valid strobe is compared, in the same cycle, against three programmable compare characters. Each compare character has a 4-bit action mask. A match can do any mix of four things: report an interrupt cause, remove the byte from the stream, pulse a transmitter stop request, or pulse a transmitter start request. Bytes that are not removed go downstream unchanged, in the same cycle as the strobe.

Software reaches the six action and character registers through one shared data port. A 3-bit select register chooses the bank and the entry. The block also counts the bytes it passes downstream in an 8-bit counter. When the counter enable is set, each change of the counter can raise its own interrupt cause. Cause codes are reported as a one-cycle pulse with a 5-bit code on the cycle after the byte.

Top module: `rx_match_engine`

## Requirements
- R1: Select bit 0 picks the bank (0 = action masks, 1 = compare characters) and select bits 2:1 pick entry 0, 1 or 2. The data port reads the selected register and writes it one edge after `data_we`. An action mask keeps only bits 3:0, and its bits 7:4 read as zero.
- R2: Select bits 2:1 equal to 11 address nothing: the data port reads zero, and a write changes no register.
- R3: In the cycle of `rx_valid`, if the byte equals any compare character whose mask has bit 1 (delete) set, `pass_valid` is low. Otherwise `pass_valid` follows `rx_valid` and `pass_data` equals `rx_data`.
- R4: In the cycle of `rx_valid`, a match whose mask has bit 2 set pulses `tx_stop`, and a match whose mask has bit 3 set pulses `tx_start`.
- R5: When stop and start are both requested for one byte, only `tx_start` pulses; the two are never high together.
- R6: A match on entry k whose mask has bit 0 set gives `irq_valid` high for one cycle, one edge after the byte, with `irq_cause` = 11000 + k (11000, 11001, 11010).
- R7: When several entries match the same byte, their action masks are ORed. The cause reported is that of the lowest-index matching entry that has its interrupt bit set.
- R8: `char_count` rises by one on the edge after each passed byte. It does not change for deleted bytes or idle cycles, and it wraps from 255 to 0.
- R9: With `cnt_irq_en` high, a passed byte that raises no match interrupt gives `irq_valid` with cause 10010 one edge later. When a match interrupt occurs on the same byte, the match cause takes precedence.
- R10: After reset, all compare characters, action masks, the select register and the count are zero, and `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_we | input | 1 | Write strobe for the select register |
| sel_wdata | input | 3 | Select value: bit 0 bank, bits 2:1 entry |
| data_we | input | 1 | Write strobe for the selected register |
| data_wdata | input | 8 | Write data for the selected register |
| data_rdata | output | 8 | Contents of the selected register |
| cnt_irq_en | input | 1 | Enables the count-change interrupt cause |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| pass_valid | output | 1 | Byte forwarded downstream |
| pass_data | output | 8 | Forwarded byte |
| tx_start | output | 1 | Transmitter start request pulse |
| tx_stop | output | 1 | Transmitter stop request pulse |
| irq_valid | output | 1 | Interrupt cause pulse |
| irq_cause | output | 5 | Interrupt cause code |
| char_count | output | 8 | Count of passed bytes |

## Verification
Pass or drop, the forwarded byte and both transmitter pulses are combinational. The bench checks them 2 ns after driving the byte, well before the next rising edge. The cause pulse and the count are due one rising edge after the byte. The driver queues their expected values, and the monitor pops and compares them at the following falling edge, one queue entry per byte. Register readback is checked at the falling edge after the select write, since the select register takes one edge to update.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  localparam int FN_W     = 4;
  localparam int FN_IRQ   = 0;
  localparam int FN_DEL   = 1;
  localparam int FN_STOP  = 2;
  localparam int FN_START = 3;
  localparam int CAUSE_W  = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_MATCH_BASE = 5'b11000;
  localparam logic [CAUSE_W-1:0] CAUSE_COUNT      = 5'b10010;
endpackage

// File: rtl/rxm_rst_sync.sv
module rxm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/rxm_regbank.sv
module rxm_regbank
  import rxm_pkg::*;
#(
  parameter int NUM_CMP = 3,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(NUM_CMP + 1),
  localparam int SEL_W  = IDX_W + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sel_we,
  input  logic [SEL_W-1:0]               sel_wdata,
  input  logic                           data_we,
  input  logic [DATA_W-1:0]              data_wdata,
  output logic [DATA_W-1:0]              data_rdata,
  output logic [NUM_CMP-1:0][DATA_W-1:0] chars,
  output logic [NUM_CMP-1:0][FN_W-1:0]   funcs
);
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [IDX_W-1:0] idx;
  logic             bank_char;

  always_comb begin
    sel_d = sel_q;
    if (sel_we) sel_d = sel_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign idx       = sel_q[SEL_W-1:1];
  assign bank_char = sel_q[0];

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_entry
    logic hit, char_we, fn_we;
    assign hit     = data_we && (idx == IDX_W'(g));
    assign char_we = hit && bank_char;
    assign fn_we   = hit && !bank_char;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       chars[g] <= '0;
      else if (char_we) chars[g] <= data_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     funcs[g] <= '0;
      else if (fn_we) funcs[g] <= data_wdata[FN_W-1:0];
    end
  end

  always_comb begin
    data_rdata = '0;
    for (int i = 0; i < NUM_CMP; i++) begin
      if (idx == IDX_W'(i)) begin
        data_rdata = bank_char ? chars[i] : {{(DATA_W-FN_W){1'b0}}, funcs[i]};
      end
    end
  end
endmodule

// File: rtl/rxm_matcher.sv
module rxm_matcher
  import rxm_pkg::*;
#(
  parameter int NUM_CMP = 3,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(NUM_CMP + 1)
) (
  input  logic                           rx_valid,
  input  logic [DATA_W-1:0]              rx_data,
  input  logic [NUM_CMP-1:0][DATA_W-1:0] chars,
  input  logic [NUM_CMP-1:0][FN_W-1:0]   funcs,
  output logic [FN_W-1:0]                act,
  output logic                           irq_hit,
  output logic [IDX_W-1:0]               irq_idx
);
  logic [NUM_CMP-1:0] eq;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    assign eq[g] = rx_valid && (chars[g] == rx_data);
  end

  always_comb begin
    act     = '0;
    irq_hit = 1'b0;
    irq_idx = '0;
    for (int i = NUM_CMP - 1; i >= 0; i--) begin
      if (eq[i]) begin
        act = act | funcs[i];
        if (funcs[i][FN_IRQ]) begin
          irq_hit = 1'b1;
          irq_idx = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/rxm_counter.sv
module rxm_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = count;
    if (inc) count_d = count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end
endmodule

// File: rtl/rx_match_engine.sv
module rx_match_engine
  import rxm_pkg::*;
#(
  parameter int NUM_CMP = 3,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 8,
  localparam int IDX_W  = $clog2(NUM_CMP + 1),
  localparam int SEL_W  = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_we,
  input  logic [SEL_W-1:0]   sel_wdata,
  input  logic               data_we,
  input  logic [DATA_W-1:0]  data_wdata,
  output logic [DATA_W-1:0]  data_rdata,
  input  logic               cnt_irq_en,
  input  logic               rx_valid,
  input  logic [DATA_W-1:0]  rx_data,
  output logic               pass_valid,
  output logic [DATA_W-1:0]  pass_data,
  output logic               tx_start,
  output logic               tx_stop,
  output logic               irq_valid,
  output logic [CAUSE_W-1:0] irq_cause,
  output logic [CNT_W-1:0]   char_count
);
  logic                           rst_i_n;
  logic [NUM_CMP-1:0][DATA_W-1:0] chars;
  logic [NUM_CMP-1:0][FN_W-1:0]   funcs;
  logic [FN_W-1:0]                act;
  logic                           irq_hit;
  logic [IDX_W-1:0]               irq_idx;
  logic                           irq_valid_d;
  logic [CAUSE_W-1:0]             irq_cause_d;

  rxm_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  rxm_regbank #(.NUM_CMP(NUM_CMP), .DATA_W(DATA_W)) i_regbank (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .sel_we     (sel_we),
    .sel_wdata  (sel_wdata),
    .data_we    (data_we),
    .data_wdata (data_wdata),
    .data_rdata (data_rdata),
    .chars      (chars),
    .funcs      (funcs)
  );

  rxm_matcher #(.NUM_CMP(NUM_CMP), .DATA_W(DATA_W)) i_matcher (
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .chars    (chars),
    .funcs    (funcs),
    .act      (act),
    .irq_hit  (irq_hit),
    .irq_idx  (irq_idx)
  );

  assign pass_valid = rx_valid && !act[FN_DEL];
  assign pass_data  = rx_data;
  assign tx_start   = act[FN_START];
  assign tx_stop    = act[FN_STOP] && !act[FN_START];

  rxm_counter #(.CNT_W(CNT_W)) i_counter (
    .clk   (clk),
    .rst_n (rst_i_n),
    .inc   (pass_valid),
    .count (char_count)
  );

  always_comb begin
    irq_valid_d = irq_hit || (pass_valid && cnt_irq_en);
    irq_cause_d = irq_hit ? (CAUSE_MATCH_BASE + CAUSE_W'(irq_idx)) : CAUSE_COUNT;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      irq_valid <= 1'b0;
      irq_cause <= '0;
    end else begin
      irq_valid <= irq_valid_d;
      irq_cause <= irq_cause_d;
    end
  end
endmodule

// File: rtl/rxm_checker.sv
module rxm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cnt_irq_en,
  input logic       rx_valid,
  input logic       pass_valid,
  input logic       tx_start,
  input logic       tx_stop,
  input logic       irq_valid,
  input logic [4:0] irq_cause,
  input logic [7:0] char_count
);
  // R5
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_start && tx_stop));

  // R3
  pass_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_valid |-> rx_valid);

  // R4
  tx_pulse_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start || tx_stop) |-> rx_valid);

  // R6
  irq_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(rx_valid));

  // R6
  irq_cause_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((irq_cause[4:3] == 2'b11 && irq_cause[2:0] < 3'd3) ||
                   irq_cause == 5'b10010));

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_valid |=> (char_count == $past(char_count) + 8'd1));

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_valid |=> $stable(char_count));

  // R9
  count_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_valid && cnt_irq_en) |=> irq_valid);
endmodule

bind rx_match_engine rxm_checker i_rxm_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_irq_en (cnt_irq_en),
  .rx_valid   (rx_valid),
  .pass_valid (pass_valid),
  .tx_start   (tx_start),
  .tx_stop    (tx_stop),
  .irq_valid  (irq_valid),
  .irq_cause  (irq_cause),
  .char_count (char_count)
);

// File: tb/test_rx_match_engine.sv
module test_rx_match_engine;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel_we;
  logic [2:0] sel_wdata;
  logic       data_we;
  logic [7:0] data_wdata;
  logic [7:0] data_rdata;
  logic       cnt_irq_en;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       pass_valid;
  logic [7:0] pass_data;
  logic       tx_start;
  logic       tx_stop;
  logic       irq_valid;
  logic [4:0] irq_cause;
  logic [7:0] char_count;

  always #10 clk = ~clk;

  rx_match_engine i_rx_match_engine (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .data_rdata(data_rdata),
    .cnt_irq_en(cnt_irq_en), .rx_valid(rx_valid), .rx_data(rx_data),
    .pass_valid(pass_valid), .pass_data(pass_data), .tx_start(tx_start),
    .tx_stop(tx_stop), .irq_valid(irq_valid), .irq_cause(irq_cause),
    .char_count(char_count)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0]  mc [3];
  logic [3:0]  mf [3];
  logic [7:0]  mcnt;
  logic [13:0] sbq [$];
  bit          done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid = 1'b0;
    end
  endtask

  task automatic wsel(input logic [2:0] v);
    @(negedge clk);
    sel_we = 1'b1; sel_wdata = v;
    @(negedge clk);
    sel_we = 1'b0;
  endtask

  task automatic wreg(input logic bank, input logic [1:0] idx, input logic [7:0] val);
    wsel({idx, bank});
    data_we = 1'b1; data_wdata = val;
    @(negedge clk);
    data_we = 1'b0;
    if (idx != 2'd3) begin
      if (bank) mc[idx] = val;
      else      mf[idx] = val[3:0];
    end
  endtask

  task automatic rreg(input logic bank, input logic [1:0] idx, input logic [7:0] exp, input string req);
    wsel({idx, bank});
    #2;
    chk(req, data_rdata, exp);
  endtask

  // Driver: drives one byte, checks same-cycle results, queues next-edge results
  task automatic send(input logic [7:0] b);
    logic [3:0] a;
    logic       ih;
    logic [4:0] cause;
    logic       iv;
    a = '0; ih = 1'b0; cause = 5'b0;
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    #2;
    for (int i = 2; i >= 0; i--) begin
      if (mc[i] == b) begin
        a = a | mf[i];
        if (mf[i][0]) begin ih = 1'b1; cause = 5'b11000 + 5'(i); end
      end
    end
    // R3
    chk("R3 pass_valid", pass_valid, !a[1]);
    if (!a[1]) chk("R3 pass_data", pass_data, b);
    // R4 R5 R7
    chk("R4 R5 R7 tx_start", tx_start, a[3]);
    chk("R4 R5 R7 tx_stop", tx_stop, a[2] && !a[3]);
    iv = ih || (!a[1] && cnt_irq_en);
    if (!ih) cause = 5'b10010;
    if (!a[1]) mcnt = mcnt + 8'd1;
    sbq.push_back({iv, cause, mcnt});
  endtask

  // Monitor: compares next-edge results in order
  always @(negedge clk) begin
    logic [13:0] it;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      // R6 R9
      chk("R6 R9 irq_valid", irq_valid, it[13]);
      if (it[13]) chk("R6 R7 R9 irq_cause", irq_cause, it[12:8]);
      // R8
      chk("R8 char_count", char_count, it[7:0]);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel_we = 1'b0; sel_wdata = '0; data_we = 1'b0; data_wdata = '0;
    cnt_irq_en = 1'b0; rx_valid = 1'b0; rx_data = '0; mcnt = '0;
    for (int i = 0; i < 3; i++) begin mc[i] = '0; mf[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk("R10 char_count", char_count, 0);
    chk("R10 irq_valid", irq_valid, 0);
    for (int i = 0; i < 3; i++) begin
      rreg(1'b1, 2'(i), 8'h00, "R10 char reg");
      rreg(1'b0, 2'(i), 8'h00, "R10 func reg");
    end

    // R1 bank and index decoding, mask upper bits
    wreg(1'b1, 2'd0, 8'h41); wreg(1'b0, 2'd0, 8'hF1);
    wreg(1'b1, 2'd1, 8'h13); wreg(1'b0, 2'd1, 8'h06);
    wreg(1'b1, 2'd2, 8'h11); wreg(1'b0, 2'd2, 8'h08);
    rreg(1'b1, 2'd0, 8'h41, "R1 char0");
    rreg(1'b1, 2'd1, 8'h13, "R1 char1");
    rreg(1'b1, 2'd2, 8'h11, "R1 char2");
    rreg(1'b0, 2'd0, 8'h01, "R1 func0 upper zero");
    rreg(1'b0, 2'd1, 8'h06, "R1 func1");
    rreg(1'b0, 2'd2, 8'h08, "R1 func2");

    // R2 index 3 ignored
    wreg(1'b1, 2'd3, 8'h55);
    wreg(1'b0, 2'd3, 8'h0F);
    rreg(1'b1, 2'd3, 8'h00, "R2 read char idx3");
    rreg(1'b0, 2'd3, 8'h00, "R2 read func idx3");
    for (int i = 0; i < 3; i++) begin
      rreg(1'b1, 2'(i), mc[i], "R2 chars untouched");
      rreg(1'b0, 2'(i), {4'h0, mf[i]}, "R2 funcs untouched");
    end

    // R3 R4 R6 R8 back-to-back stream
    send(8'h20); send(8'h41); send(8'h13); send(8'h11); send(8'h41);
    idle(3);

    // R9 count interrupt and precedence
    cnt_irq_en = 1'b1;
    send(8'h30); send(8'h41); send(8'h13); send(8'h77);
    idle(3);
    cnt_irq_en = 1'b0;

    // R5 R7 duplicate matches, start wins, lowest index cause
    wreg(1'b1, 2'd2, 8'h41); wreg(1'b0, 2'd2, 8'h0D);
    wreg(1'b0, 2'd1, 8'h0C);
    send(8'h41); send(8'h13);
    idle(3);
    wreg(1'b0, 2'd0, 8'h00);
    send(8'h41);
    idle(3);
    wreg(1'b1, 2'd1, 8'h41); wreg(1'b0, 2'd1, 8'h03);
    send(8'h41);
    idle(3);

    // R8 wrap from 255 to 0
    begin
      int n;
      n = 256 - int'(mcnt);
      for (int k = 0; k < n; k++) send(8'h00);
      idle(3);
      chk("R8 wrap to zero", char_count, 8'h00);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule